// File: doc/BRIEF.md
# Half-Step Fractional Clock Prescaler

This block slows down its input clock by a ratio that can be set in steps of one half. The ratio comes from a 6-bit code, and the divided clock drives a baud-rate generator further down the chain. A host sets the code with a register write. The write only counts while a separate divisor-access control bit is set. The code is taken from the low six bits of the write data, and the upper bits are dropped.

Code 0 stops the output and holds it high. Codes 1, 2 and 3 all pass the input clock straight through. Any larger code divides by code/2, so odd codes give ratios such as 2.5 or 31.5. A half ratio N+0.5 is made by alternating output periods of N and N+1 input cycles. This keeps the average ratio exact.

Every output period starts with its high phase, which lasts floor(length/2) cycles. A new code is only adopted at the end of a period, so a code change never produces a shortened pulse. Everything runs on the rising edge of the one input clock.

Top module: `halfstep_prescaler`

## Requirements
- R1: After synchronous reset the stored code is 0 and the output is held at logic 1.
- R2: On a rising edge where `wr_en` and `div_access` are both 1, the code is loaded from `wr_data[5:0]`, and `wr_data[7:6]` have no effect on the output.
- R3: A write with `div_access` at 0 leaves the stored code, and therefore the output waveform, unchanged.
- R4: With code 0 in effect, the output stays at logic 1 for as long as the code remains 0.
- R5: With code 1, 2 or 3 in effect, `clk_out` equals `clk` (high while `clk` is high, low while it is low).
- R6: With an even code C of 4 or more, every output period is C/2 input cycles long. It consists of floor(C/4) high cycles followed by the remaining low cycles.
- R7: With an odd code C of 5 or more and N = floor(C/2), output periods alternate between N and N+1 cycles, starting with N when division begins from a stopped state. Each period is high for floor(length/2) cycles first.
- R8: A code change takes effect only at the end of the current output period, so no high or low run is shorter than the runs of the old code or the new code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe for the shared register |
| div_access | input | 1 | Divisor-access control bit; writes load the code only while it is 1 |
| wr_data | input | 8 | Write data; bits 5:0 carry the prescale code |
| clk_out | output | 1 | Divided clock to the baud-rate generator |

## Verification
The assertions check on every cycle that:
- the code register loads only on an enabled write and otherwise holds;
- the period counter stays below the period length;
- the period length and the effective code never change in the middle of a period;
- periods of an odd code alternate in length;
- a stopped prescaler drives a high output.

Only the bench scenarios can show the actual shape of the waveform. The bench measures high and low run lengths for integer codes, half-step codes and the largest code, and checks the pass-through levels for codes 1 to 3. It also checks that a gated write and a mid-period code change leave no stray short pulse.

// File: rtl/hsp_pkg.sv
package hsp_pkg;

    localparam int CODE_W = 6;
    localparam int LEN_W  = CODE_W;
    localparam int BYPASS_MAX = 3;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [LEN_W-1:0]  len_t;

    typedef enum logic [1:0] {
        MODE_STOP   = 2'd0,
        MODE_BYPASS = 2'd1,
        MODE_DIV    = 2'd2
    } mode_e;

    typedef struct packed {
        mode_e mode;
        code_t code;
        len_t  cnt;
        len_t  len;
        logic  alt;
        logic  out;
    } div_state_t;

    function automatic mode_e decode_mode(code_t c);
        if (c == '0)
            return MODE_STOP;
        else if (c <= code_t'(BYPASS_MAX))
            return MODE_BYPASS;
        else
            return MODE_DIV;
    endfunction

    function automatic len_t period_len(code_t c, logic alt_sel);
        return len_t'(c >> 1) + len_t'(c[0] & alt_sel);
    endfunction

    function automatic len_t high_len(len_t l);
        return l >> 1;
    endfunction

endpackage

// File: rtl/hsp_code_reg.sv
module hsp_code_reg
    import hsp_pkg::*;
#(
    parameter int WR_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic            div_access,
    input  logic [WR_W-1:0] wr_data,
    output code_t           code_o
);

    logic  load_en;
    code_t code_q;

    assign load_en = wr_en && div_access;

    always_ff @(posedge clk) begin
        if (rst)
            code_q <= '0;
        else if (load_en)
            code_q <= wr_data[CODE_W-1:0];
    end

    assign code_o = code_q;

    assert_code_load_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && div_access) |=> (code_o == $past(wr_data[CODE_W-1:0])));

    assert_code_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && div_access) |=> $stable(code_o));

endmodule

// File: rtl/hsp_period_ctrl.sv
module hsp_period_ctrl
    import hsp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  code_t code_i,
    output mode_e mode_o,
    output logic  div_out_o
);

    div_state_t st_q;
    div_state_t st_d;
    logic       boundary;
    logic       alt_use;
    mode_e      next_mode;

    assign boundary  = (st_q.mode != MODE_DIV) || (st_q.cnt == st_q.len - len_t'(1));
    assign alt_use   = (st_q.mode == MODE_DIV) ? st_q.alt : 1'b0;
    assign next_mode = decode_mode(code_i);

    always_comb begin
        st_d = st_q;
        if (boundary) begin
            st_d.code = code_i;
            st_d.mode = next_mode;
            st_d.cnt  = '0;
            if (next_mode == MODE_DIV) begin
                st_d.len = period_len(code_i, alt_use);
                st_d.alt = code_i[0] & ~alt_use;
            end else begin
                st_d.len = len_t'(1);
                st_d.alt = 1'b0;
            end
        end else begin
            st_d.cnt = st_q.cnt + len_t'(1);
        end
        if (st_d.mode == MODE_DIV)
            st_d.out = (st_d.cnt < high_len(st_d.len));
        else
            st_d.out = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.mode <= MODE_STOP;
            st_q.code <= '0;
            st_q.cnt  <= '0;
            st_q.len  <= len_t'(1);
            st_q.alt  <= 1'b0;
            st_q.out  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o    = st_q.mode;
    assign div_out_o = st_q.out;

    assert_cnt_in_period_R6: assert property (@(posedge clk) disable iff (rst)
        (st_q.mode == MODE_DIV) |-> (st_q.cnt < st_q.len));

    assert_len_hold_mid_period_R8: assert property (@(posedge clk) disable iff (rst)
        (st_q.mode == MODE_DIV && st_q.cnt != '0) |-> (st_q.len == $past(st_q.len)));

    assert_code_hold_mid_period_R8: assert property (@(posedge clk) disable iff (rst)
        (st_q.mode == MODE_DIV && st_q.cnt != '0) |-> (st_q.code == $past(st_q.code)));

    assert_half_alternates_R7: assert property (@(posedge clk) disable iff (rst)
        (st_q.mode == MODE_DIV && st_q.cnt == '0 && st_q.code[0] &&
         $past(st_q.mode) == MODE_DIV && $past(st_q.code) == st_q.code)
        |-> (st_q.len != $past(st_q.len)));

endmodule

// File: rtl/hsp_out_stage.sv
module hsp_out_stage
    import hsp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  mode_e mode_i,
    input  logic  div_out_i,
    output logic  clk_out
);

    assign clk_out = (mode_i == MODE_BYPASS) ? clk : div_out_i;

    assert_stop_holds_high_R4: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_STOP) |-> clk_out);

endmodule

// File: rtl/halfstep_prescaler.sv
module halfstep_prescaler
    import hsp_pkg::*;
#(
    parameter int WR_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic            div_access,
    input  logic [WR_W-1:0] wr_data,
    output logic            clk_out
);

    code_t code_w;
    mode_e mode_w;
    logic  div_out_w;

    hsp_code_reg #(.WR_W(WR_W)) u_code (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .div_access (div_access),
        .wr_data    (wr_data),
        .code_o     (code_w)
    );

    hsp_period_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .code_i    (code_w),
        .mode_o    (mode_w),
        .div_out_o (div_out_w)
    );

    hsp_out_stage u_out (
        .clk       (clk),
        .rst       (rst),
        .mode_i    (mode_w),
        .div_out_i (div_out_w),
        .clk_out   (clk_out)
    );

    assert_reset_code_zero_R1: assert property (@(posedge clk)
        $past(rst) |-> (code_w == '0 && clk_out));

endmodule

// File: tb/tb_halfstep_prescaler.sv
module tb_halfstep_prescaler;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       div_access = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       clk_out;

    int checks = 0;
    int fails  = 0;

    halfstep_prescaler dut (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .div_access (div_access),
        .wr_data    (wr_data),
        .clk_out    (clk_out)
    );

    always #5 clk = ~clk;

    typedef struct {
        logic  lvl;
        int    len;
        string req;
    } run_t;

    run_t exp_q[$];

    logic  mon_on = 1'b0;
    logic  mon_started = 1'b0;
    logic  set_mode = 1'b0;
    int    set_a = 0;
    int    set_b = 0;
    string set_req = "";
    logic  prev_v;
    logic  cur_v;
    int    runlen = 0;
    logic  skip = 1'b0;
    run_t  item;

    always @(negedge clk) begin
        if (mon_on) begin
            cur_v = clk_out;
            if (!mon_started) begin
                prev_v = cur_v;
                runlen = 1;
                skip = 1'b1;
                mon_started = 1'b1;
            end else if (cur_v == prev_v) begin
                runlen++;
            end else begin
                if (skip) begin
                    skip = 1'b0;
                end else if (set_mode) begin
                    checks++;
                    if (runlen != set_a && runlen != set_b) begin
                        fails++;
                        $display("FAIL %s: run of level %0d lasted %0d, expected %0d or %0d",
                                 set_req, prev_v, runlen, set_a, set_b);
                    end
                end else if (exp_q.size() > 0) begin
                    item = exp_q.pop_front();
                    checks++;
                    if (item.lvl != prev_v || item.len != runlen) begin
                        fails++;
                        $display("FAIL %s: run level/len %0d/%0d, expected %0d/%0d",
                                 item.req, prev_v, runlen, item.lvl, item.len);
                    end
                end
                prev_v = cur_v;
                runlen = 1;
            end
        end else begin
            mon_started = 1'b0;
        end
    end

    task automatic check(input string req, input logic ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [7:0] data, input logic acc);
        @(negedge clk); #1;
        wr_en = 1'b1; div_access = acc; wr_data = data;
        @(negedge clk); #1;
        wr_en = 1'b0; div_access = 1'b0; wr_data = 8'h00;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_high(input string req, input int n);
        int lows = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #2;
            if (clk_out !== 1'b1) lows++;
        end
        check(req, lows == 0, lows, 0);
    endtask

    // Push expected runs for P periods of code c, starting from a stopped state.
    task automatic push_runs(input int c, input int periods, input string req);
        int n = c / 2;
        int half = c % 2;
        int total = 0;
        for (int p = 0; p < periods; p++) begin
            int l = n + ((half == 1 && (p % 2) == 1) ? 1 : 0);
            int h = l / 2;
            if (p > 0) exp_q.push_back('{1'b1, h, req});
            exp_q.push_back('{1'b0, l - h, req});
            total += l;
        end
    endtask

    task automatic run_code(input logic [7:0] data, input int c, input int periods,
                            input string req);
        write_reg(8'h00, 1'b1);
        wait_cycles(40);
        exp_q.delete();
        push_runs(c, periods, req);
        @(negedge clk); #1;
        mon_on = 1'b1; set_mode = 1'b0;
        write_reg(data, 1'b1);
        wait_cycles((c / 2 + 1) * (periods + 2) + 10);
        check({req, " all runs seen"}, exp_q.size() == 0, exp_q.size(), 0);
        @(negedge clk); #1;
        mon_on = 1'b0;
    endtask

    task automatic bypass_check(input int c);
        int bad = 0;
        write_reg(8'h00, 1'b1);
        wait_cycles(40);
        write_reg(8'(c), 1'b1);
        wait_cycles(3);
        for (int i = 0; i < 6; i++) begin
            @(posedge clk); #2;
            if (clk_out !== 1'b1) bad++;
            @(negedge clk); #2;
            if (clk_out !== 1'b0) bad++;
        end
        check($sformatf("R5 code %0d follows clk", c), bad == 0, bad, 0);
    endtask

    task automatic set_window(input int a, input int b, input string req, input int cycles);
        @(negedge clk); #1;
        set_a = a; set_b = b; set_req = req; set_mode = 1'b1; mon_on = 1'b1;
        wait_cycles(cycles);
    endtask

    initial begin
        wait_cycles(3);
        @(negedge clk); #1;
        rst = 1'b0;
        // R1: reset state holds output high
        expect_high("R1 reset output high", 20);
        // R3: gated write from stopped state leaves output high
        write_reg(8'd10, 1'b0);
        expect_high("R3 gated write while stopped", 40);
        // R6: integer ratios
        run_code(8'd8, 8, 5, "R6 code 8");
        run_code(8'd4, 4, 6, "R6 code 4");
        run_code(8'd22, 22, 4, "R6 code 22");
        // R2: upper bits ignored (0xC8 acts as code 8)
        run_code(8'hC8, 8, 5, "R2 upper bits ignored");
        // R7: half-step ratios
        run_code(8'd5, 5, 6, "R7 code 5");
        run_code(8'd13, 13, 4, "R7 code 13");
        run_code(8'd63, 63, 4, "R7 code 63");
        // R5: pass-through codes
        bypass_check(1);
        bypass_check(2);
        bypass_check(3);
        // R3: gated write while dividing keeps runs of code 8
        write_reg(8'd8, 1'b1);
        wait_cycles(10);
        @(negedge clk); #1;
        mon_on = 1'b1;
        fork
            set_window(2, 2, "R3 gated write while dividing", 60);
            begin
                wait_cycles(12);
                write_reg(8'd20, 1'b0);
            end
        join
        @(negedge clk); #1;
        mon_on = 1'b0; set_mode = 1'b0;
        // R8: change code mid-period, no short runs
        write_reg(8'd8, 1'b1);
        wait_cycles(10);
        fork
            set_window(2, 5, "R8 change at boundary", 80);
            begin
                wait_cycles(13);
                write_reg(8'd20, 1'b1);
            end
        join
        @(negedge clk); #1;
        mon_on = 1'b0; set_mode = 1'b0;
        // R4: code 0 stops the output high
        write_reg(8'd0, 1'b1);
        wait_cycles(15);
        expect_high("R4 code 0 holds high", 50);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule